// File: doc/BRIEF.md
# Byte-Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C). It sits in front of a small file of byte registers whose contents drive other logic on the chip. The bus clock and data lines come in asynchronously and are oversampled on the system clock. The block finds bus start and stop conditions, matches a fixed 7-bit target address and answers by pulling the data line low through an active-low output enable. The block never drives the line high.

A write transfer carries the address byte, then one pointer byte, then any number of data bytes. The pointer selects the register that the next data byte writes, and it steps forward after every byte. It does not wrap: once it passes the last register it parks on an out-of-range value. Data sent to an out-of-range pointer is still acknowledged but is dropped. A read transfer shifts out the byte at the pointer and steps the pointer in the same way. Out-of-range reads return zero. Register contents leave the block as one flat vector. Nothing in the block streams data, so it has no valid/ready interface. The bus sets the pace and the block never holds the clock low.

Top module: `i2c_regptr_target`

## Requirements
- R1: A fall of SDA while SCL is high is a START and begins address reception from any state. A rise of SDA while SCL is high is a STOP and returns the block to idle with SDA released.
- R2: An address byte whose upper seven bits equal TGT_ADDR is acknowledged by driving sda_oe_n low for the ninth clock. Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R3: After a write address (bit 0 = 0), the next byte is acknowledged and loaded as the pointer. Values 0x00 to NREGS-1 select a register. Any larger value puts the pointer in the out-of-range state, numerically NREGS (0x10).
- R4: Each further write byte is acknowledged and stored in the register at the pointer, and the pointer then increases by one.
- R5: The pointer never goes beyond NREGS. A byte written while the pointer is out of range is acknowledged, changes no register and leaves the pointer at NREGS.
- R6: After a read address (bit 0 = 1), the block sends the byte at the pointer MSB first and then advances the pointer, with the same saturation. An out-of-range pointer sends 0x00.
- R7: In a read, a master acknowledge (SDA low on the ninth clock) starts the next byte. A not-acknowledge releases SDA and idles the block until the next START. A STOP or START in place of the ninth clock is also accepted.
- R8: sda_oe_n changes only while SCL is low. A low on sda_oe_n means the block pulls SDA low.
- R9: A START or STOP in the middle of a byte abandons that byte. A data byte is written only after all eight bits have been received.
- R10: After reset, every register holds 0x00, the pointer is 0 and SDA is released.
- R11: Register k appears on regs_o bits [8k+7:8k].
- R12: A repeated START keeps the pointer, so a write of the pointer followed by a read address reads from that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_n | output | 1 | Active-low enable of the open-drain SDA pull-down |
| regs_o | output | NREGS*8 | All register contents, register k at [8k+7:8k] |

## Verification
The assertions rely on three properties of the bus. SCL stays low for several system clocks after each fall. The master moves SDA only while SCL is low, except when it makes a START or STOP. A STOP is never attempted while the block holds SDA low. The bench meets all three by splitting each bit into four quarters of five system clocks each and changing SDA only in the second quarter of the low phase. It makes START and STOP only after the block has released the line. A bus-side monitor in the bench flags any change of the output enable while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_RDATA
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ptr_ld,
  output logic              wr_en,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rd_take,
  output logic              drive_low,
  output logic              idle
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic              ackph;
  logic              rd_dir;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      ackph     <= 1'b0;
      rd_dir    <= 1'b0;
      sh        <= '0;
      tx        <= '0;
      drive_low <= 1'b0;
      ptr_ld    <= 1'b0;
      wr_en     <= 1'b0;
      rd_take   <= 1'b0;
    end else begin
      ptr_ld  <= 1'b0;
      wr_en   <= 1'b0;
      rd_take <= 1'b0;
      if (start_det || stop_det) begin
        phase     <= start_det ? PH_ADDR : PH_IDLE;
        cnt       <= '0;
        ackph     <= 1'b0;
        rd_dir    <= 1'b0;
        drive_low <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (phase == PH_RDATA) begin
            if (ackph) begin
              if (sda_s) begin
                phase <= PH_IDLE;
                ackph <= 1'b0;
              end
            end else if (cnt < FULL) begin
              cnt <= cnt + 1'b1;
            end
          end else if (!ackph && cnt < FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end
        end else if (scl_fall) begin
          if (phase == PH_RDATA) begin
            if (ackph) begin
              ackph     <= 1'b0;
              cnt       <= '0;
              tx        <= rd_data;
              rd_take   <= 1'b1;
              drive_low <= ~rd_data[BYTE_W-1];
            end else if (cnt < FULL) begin
              tx        <= {tx[BYTE_W-2:0], 1'b0};
              drive_low <= ~tx[BYTE_W-2];
            end else begin
              drive_low <= 1'b0;
              ackph     <= 1'b1;
            end
          end else if (ackph) begin
            ackph <= 1'b0;
            cnt   <= '0;
            if (rd_dir) begin
              phase     <= PH_RDATA;
              tx        <= rd_data;
              rd_take   <= 1'b1;
              drive_low <= ~rd_data[BYTE_W-1];
            end else begin
              drive_low <= 1'b0;
            end
          end else if (cnt == FULL) begin
            unique case (phase)
              PH_ADDR: begin
                if (sh[BYTE_W-1:1] == TGT_ADDR) begin
                  ackph     <= 1'b1;
                  drive_low <= 1'b1;
                  rd_dir    <= sh[0];
                  if (!sh[0]) phase <= PH_PTR;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_PTR: begin
                ackph     <= 1'b1;
                drive_low <= 1'b1;
                ptr_ld    <= 1'b1;
                phase     <= PH_WDATA;
              end
              PH_WDATA: begin
                ackph     <= 1'b1;
                drive_low <= 1'b1;
                wr_en     <= 1'b1;
              end
              default: phase <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign rx_byte = sh;
  assign idle    = (phase == PH_IDLE);
endmodule

// File: rtl/i2c_ptr_regfile.sv
module i2c_ptr_regfile
  import i2c_tgt_pkg::*;
#(
  parameter int NREGS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ptr_ld,
  input  logic                    wr_en,
  input  logic [BYTE_W-1:0]       wr_byte,
  input  logic                    rd_take,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [$clog2(NREGS+1)-1:0] ptr_o,
  output logic [NREGS*BYTE_W-1:0] regs_o
);
  localparam int PTR_W = $clog2(NREGS + 1);
  localparam int IDX_W = $clog2(NREGS);
  localparam logic [PTR_W-1:0] PARK = PTR_W'(NREGS);

  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] mem [NREGS];
  logic              in_range;

  assign in_range = (ptr < PARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_ld) begin
      ptr <= (int'(wr_byte) < NREGS) ? PTR_W'(wr_byte) : PARK;
    end else if ((wr_en || rd_take) && in_range) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[k] <= '0;
      else if (wr_en && ptr == PTR_W'(k)) mem[k] <= wr_byte;
    end
    assign regs_o[k*BYTE_W +: BYTE_W] = mem[k];
  end

  assign rd_data = in_range ? mem[ptr[IDX_W-1:0]] : '0;
  assign ptr_o   = ptr;
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h2A,
  parameter int         NREGS       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_n,
  output logic [NREGS*BYTE_W-1:0] regs_o
);
  localparam int PTR_W = $clog2(NREGS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_ld, wr_en, rd_take, drive_low, eng_idle;
  logic [BYTE_W-1:0] rx_byte, rd_data;
  logic [PTR_W-1:0]  ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .ptr_ld(ptr_ld), .wr_en(wr_en), .rx_byte(rx_byte),
    .rd_take(rd_take), .drive_low(drive_low), .idle(eng_idle)
  );

  i2c_ptr_regfile #(.NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .wr_en(wr_en),
    .wr_byte(rx_byte), .rd_take(rd_take), .rd_data(rd_data),
    .ptr_o(ptr), .regs_o(regs_o)
  );

  assign sda_oe_n = ~drive_low;
endmodule

// File: rtl/i2c_regptr_chk.sv
module i2c_regptr_chk #(
  parameter int NREGS = 16,
  parameter int PTR_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               sda_oe_n,
  input logic               wr_en,
  input logic               idle,
  input logic [PTR_W-1:0]   ptr,
  input logic [NREGS*8-1:0] regs
);
  localparam logic [PTR_W-1:0] PARK = PTR_W'(NREGS);

  AST_PTR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PARK); // R5

  AST_PTR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == PARK) |=> (ptr == PARK)); // R5

  AST_DROP_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == PARK) |=> $stable(regs)); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr < PARK) |=> (ptr == $past(ptr) + 1'b1)); // R4

  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_n) |-> !scl_s); // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> sda_oe_n); // R1
endmodule

bind i2c_regptr_target i2c_regptr_chk #(
  .NREGS(NREGS), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe_n(sda_oe_n),
  .wr_en(wr_en), .idle(eng_idle), .ptr(ptr), .regs(regs_o)
);

// File: tb/i2c_regptr_target_test.sv
module i2c_regptr_target_test;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int NR = 16;
  localparam int Q  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_n;
  logic [NR*8-1:0] regs_o;
  wire sda_bus = sda_m & sda_oe_n;

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  logic [7:0] model [NR];

  always #2 clk = ~clk;

  i2c_regptr_target #(.TGT_ADDR(ADDR), .NREGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_n(sda_oe_n), .regs_o(regs_o)
  );

  // Bus-side monitor: output enable must not move while SCL is high (R8)
  logic scl_prev = 1'b1, oe_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe_n !== oe_prev) viol++;
    scl_prev = scl_m;
    oe_prev  = sda_oe_n;
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic check_regs(input string tag);
    logic [NR*8-1:0] e;
    for (int k = 0; k < NR; k++) e[k*8 +: 8] = model[k];
    check(regs_o === e, tag, regs_o, e);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input bit b, output bit seen);
    wq(); sda_m = b; wq(); scl_m = 1'b1; wq(); seen = sda_bus; wq(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit do_ack_clk, input bit m_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    if (do_ack_clk) clk_bit(~m_ack, s);
  endtask

  task automatic t_reset();
    check(sda_oe_n === 1'b1, "R10 sda released", sda_oe_n, 1);
    check_regs("R10 R11 regs zero");
  endtask

  task automatic t_write_basic();
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, "R2 addr ack", a, 1);
    send_byte(8'h03, a);        check(a, "R3 ptr ack", a, 1);
    send_byte(8'hA5, a);        check(a, "R4 data ack", a, 1);
    send_byte(8'h5A, a);
    send_byte(8'hC3, a);        check(a, "R4 third ack", a, 1);
    bus_stop();
    model[3] = 8'hA5; model[4] = 8'h5A; model[5] = 8'hC3;
    check_regs("R4 R11 burst write");
    check(sda_oe_n === 1'b1, "R1 stop releases", sda_oe_n, 1);
  endtask

  task automatic t_wrong_addr();
    bit a;
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, a); check(!a, "R2 foreign addr nack", a, 0);
    send_byte(8'h00, a);                check(!a, "R2 ignored byte nack", a, 0);
    send_byte(8'hFF, a);
    bus_stop();
    check_regs("R2 foreign write no effect");
  endtask

  task automatic t_read();
    bit a; logic [7:0] b;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h03, a);
    bus_start();
    send_byte({ADDR, 1'b1}, a); check(a, "R12 read addr ack", a, 1);
    recv_byte(1, 1, b); check(b === 8'hA5, "R6 R12 read first", b, 8'hA5);
    recv_byte(1, 1, b); check(b === 8'h5A, "R7 read after ack", b, 8'h5A);
    recv_byte(0, 0, b); check(b === 8'hC3, "R6 read third", b, 8'hC3);
    bus_stop();
    check(sda_oe_n === 1'b1, "R7 stop w/o nack releases", sda_oe_n, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1, 0, b); check(b === 8'h00, "R6 pointer advanced to 6", b, 0);
    recv_byte(0, 0, b); check(b === 8'hFF, "R7 nack releases line", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_saturate();
    bit a; logic [7:0] b;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h0E, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a); check(a, "R5 past-end ack", a, 1);
    model[14] = 8'h11; model[15] = 8'h22;
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1, 0, b); check(b === 8'h00, "R5 R6 parked read zero", b, 0);
    bus_stop();
    check_regs("R5 no wrap");
  endtask

  task automatic t_invalid_ptr();
    bit a; logic [7:0] b;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h40, a); check(a, "R3 bad ptr ack", a, 1);
    send_byte(8'h77, a); check(a, "R5 dropped ack", a, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1, 0, b); check(b === 8'h00, "R3 R6 bad ptr read zero", b, 0);
    bus_stop();
    check_regs("R5 bad ptr drops data");
  endtask

  task automatic t_abort();
    bit a, s;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h08, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    scl_m = 1'b0; bus_stop();
    check_regs("R9 stop mid byte");
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'h08, a);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, "R1 restart mid byte", a, 1);
    send_byte(8'h09, a);
    send_byte(8'h99, a);
    bus_stop();
    model[9] = 8'h99;
    check_regs("R9 R1 partial byte dropped");
  endtask

  bit done = 0;
  initial begin
    for (int k = 0; k < NR; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_basic();
    t_wrong_addr();
    t_read();
    t_saturate();
    t_invalid_ptr();
    t_abort();
    check(viol == 0, "R8 enable moved with SCL high", viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule